// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block derives the negative, zero, carry and overflow flags for a W-bit ALU operation (W is 32 by default). The execute stage hands it both operands, the finished result, the adder's carry out, the shifter's carry out, the current carry and overflow flags, a two-bit operation class and a flag-set enable. The block does not contain the adder or the shifter. It only applies the flag rules for the selected class.

The new flag values and one update enable per flag are registered, so they appear one clock after the inputs. The consumer writes each flag into its status word only when that flag's enable is high. When the carry or overflow flag is not updated, its output repeats the old value that came in on `c_in` or `v_in`.

The operation class is encoded as follows:
- 2'b00: addition
- 2'b01: subtraction or compare, computed by the adder as a + ~b + 1
- 2'b10: logical operation that passes through the shifter
- 2'b11: logical operation that does not use the shifter

Top module: `flag_gen_top`

## Requirements
- R1: `flag_n` equals bit W-1 of the result.
- R2: `flag_z` is 1 exactly when every result bit is 0. For a compare this means the operands are equal.
- R3: For class 2'b00 (add), `flag_c` equals the adder carry out, which marks an unsigned carry out of the top bit.
- R4: For class 2'b01 (subtract), `flag_c` equals the adder carry out. A value of 1 means no unsigned borrow, so it is 1 exactly when a >= b unsigned.
- R5: For add, `flag_v` is 1 when both operands have the same sign and the result's sign differs from it.
- R6: For subtract, `flag_v` is 1 when the operands' signs differ and the result's sign differs from a's sign.
- R7: For class 2'b10 (logical with shifter), `flag_c` equals `shf_cout`, `flag_v` equals `v_in`, and `upd_v` is 0.
- R8: For class 2'b11 (logical without shifter), `flag_c` equals `c_in`, `flag_v` equals `v_in`, and both `upd_c` and `upd_v` are 0.
- R9: When `set_en` is 0, all four update enables are 0, and `flag_c` and `flag_v` repeat `c_in` and `v_in`.
- R10: When `set_en` is 1, the enables are set as follows:
  - `upd_n` and `upd_z` are 1 for every class.
  - `upd_c` is 1 for classes 00, 01 and 10.
  - `upd_v` is 1 for classes 00 and 01.
- R11: All outputs are registered. They show the inputs from one clock earlier, and they are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the output registers |
| set_en | input | 1 | Flag-set enable for this operation |
| op_class | input | 2 | Operation class (00 add, 01 sub, 10 logical+shift, 11 logical) |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| result | input | W | ALU result |
| add_cout | input | 1 | Carry out of the adder's top bit |
| shf_cout | input | 1 | Last bit shifted out by the shifter |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_v | output | 1 | New overflow flag |
| upd_n | output | 1 | Write enable for the negative flag |
| upd_z | output | 1 | Write enable for the zero flag |
| upd_c | output | 1 | Write enable for the carry flag |
| upd_v | output | 1 | Write enable for the overflow flag |

## Verification
Every flag and every enable is due exactly one rising edge after its inputs are presented. The bench drives inputs on a falling edge and samples the outputs on the next falling edge, half a period after the capturing rising edge. The bench computes the result and carry it feeds the block with its own W+1-bit model of the adder. The expected flags in its table are worked out by hand for the signed and unsigned boundary values.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGSH = 2'b10,
        OPC_LOG   = 2'b11
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/flag_nz.sv
module flag_nz #(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    output logic         n_nx,
    output logic         z_nx
);
    localparam int MSB = W - 1;

    always_comb begin
        n_nx = result[MSB];
        z_nx = ~|result;
    end
endmodule

// File: rtl/flag_cv.sv
module flag_cv
    import flag_gen_pkg::*;
(
    input  op_class_e op,
    input  logic      set_en,
    input  logic      a_msb,
    input  logic      b_msb,
    input  logic      r_msb,
    input  logic      add_cout,
    input  logic      shf_cout,
    input  logic      c_in,
    input  logic      v_in,
    output logic      c_nx,
    output logic      v_nx,
    output logic      upd_c,
    output logic      upd_v
);
    logic b_eff;
    logic ovf;

    always_comb begin
        // subtraction adds ~b, so the sign test uses b's inverted sign
        b_eff = (op == OPC_SUB) ? ~b_msb : b_msb;
        ovf   = (a_msb == b_eff) && (r_msb != a_msb);
        upd_c = 1'b0;
        upd_v = 1'b0;
        c_nx  = c_in;
        v_nx  = v_in;
        unique case (op)
            OPC_ADD, OPC_SUB: begin
                upd_c = set_en;
                upd_v = set_en;
            end
            OPC_LOGSH: upd_c = set_en;
            OPC_LOG:   ;
            default:   ;
        endcase
        if (upd_c) c_nx = (op == OPC_LOGSH) ? shf_cout : add_cout;
        if (upd_v) v_nx = ovf;
    end
endmodule

// File: rtl/flag_gen_top.sv
module flag_gen_top
    import flag_gen_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [1:0]   op_class,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] result,
    input  logic         add_cout,
    input  logic         shf_cout,
    input  logic         c_in,
    input  logic         v_in,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v,
    output logic         upd_n,
    output logic         upd_z,
    output logic         upd_c,
    output logic         upd_v
);
    localparam int MSB = W - 1;

    op_class_e op;
    nzcv_t     nx_flags, q_flags;
    nzcv_t     nx_upd, q_upd;
    logic      uc, uv;

    assign op = op_class_e'(op_class);

    flag_nz #(.W(W)) u_nz (
        .result (result),
        .n_nx   (nx_flags.n),
        .z_nx   (nx_flags.z)
    );

    flag_cv u_cv (
        .op       (op),
        .set_en   (set_en),
        .a_msb    (opnd_a[MSB]),
        .b_msb    (opnd_b[MSB]),
        .r_msb    (result[MSB]),
        .add_cout (add_cout),
        .shf_cout (shf_cout),
        .c_in     (c_in),
        .v_in     (v_in),
        .c_nx     (nx_flags.c),
        .v_nx     (nx_flags.v),
        .upd_c    (uc),
        .upd_v    (uv)
    );

    always_comb begin
        nx_upd.n = set_en;
        nx_upd.z = set_en;
        nx_upd.c = uc;
        nx_upd.v = uv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_flags <= '0;
            q_upd   <= '0;
        end else begin
            q_flags <= nx_flags;
            q_upd   <= nx_upd;
        end
    end

    assign flag_n = q_flags.n;
    assign flag_z = q_flags.z;
    assign flag_c = q_flags.c;
    assign flag_v = q_flags.v;
    assign upd_n  = q_upd.n;
    assign upd_z  = q_upd.z;
    assign upd_c  = q_upd.c;
    assign upd_v  = q_upd.v;
endmodule

// File: rtl/flag_gen_chk.sv
module flag_gen_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         set_en,
    input logic [1:0]   op_class,
    input logic [W-1:0] result,
    input logic         shf_cout,
    input logic         c_in,
    input logic         v_in,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v,
    input logic         upd_n,
    input logic         upd_z,
    input logic         upd_c,
    input logic         upd_v
);
    a_r1_n_msb: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flag_n == $past(result[W-1]));

    a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flag_z == ($past(result) == '0));

    a_r7_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && op_class == 2'b10) |=> (flag_c == $past(shf_cout)) && (flag_v == $past(v_in)) && !upd_v);

    a_r8_logic_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11) |=> !upd_c && !upd_v && flag_c == $past(c_in) && flag_v == $past(v_in));

    a_r9_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en |=> !upd_n && !upd_z && !upd_c && !upd_v);

    a_r10_nz_enable: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> upd_n && upd_z);
endmodule

bind flag_gen_top flag_gen_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .op_class (op_class),
    .result   (result),
    .shf_cout (shf_cout),
    .c_in     (c_in),
    .v_in     (v_in),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v),
    .upd_n    (upd_n),
    .upd_z    (upd_z),
    .upd_c    (upd_c),
    .upd_v    (upd_v)
);

// File: tb/test_flag_gen_top.sv
module test_flag_gen_top;
    localparam int W = 32;
    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_en = 1'b0;
    logic [1:0]   op_class = 2'b00;
    logic [W-1:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic         add_cout = 1'b0, shf_cout = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic         flag_n, flag_z, flag_c, flag_v;
    logic         upd_n, upd_z, upd_c, upd_v;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flag_gen_top #(.W(W)) i_flag_gen_top (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .op_class(op_class),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .add_cout(add_cout), .shf_cout(shf_cout), .c_in(c_in), .v_in(v_in),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c), .upd_v(upd_v)
    );

    // {op, a, b, expected nzcv}
    localparam logic [69:0] VEC [NV] = '{
        {2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 4'b1001},
        {2'b01, 32'h8000_0000, 32'h0000_0001, 4'b0011},
        {2'b01, 32'h0000_0000, 32'h0000_0000, 4'b0110},
        {2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0110},
        {2'b01, 32'h0000_0001, 32'h0000_0002, 4'b1000},
        {2'b00, 32'h8000_0000, 32'h8000_0000, 4'b0111},
        {2'b01, 32'h0000_0005, 32'h0000_0005, 4'b0110},
        {2'b00, 32'h0000_0001, 32'h0000_0002, 4'b0000}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive_arith(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] sum;
        sum = (op == 2'b01) ? ({1'b0, a} + {1'b0, ~b} + 1) : ({1'b0, a} + {1'b0, b});
        op_class = op;
        opnd_a   = a;
        opnd_b   = b;
        result   = sum[W-1:0];
        add_cout = sum[W];
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11 reset flags", {flag_n, flag_z, flag_c, flag_v}, 4'b0000);
        check("R11 reset enables", {upd_n, upd_z, upd_c, upd_v}, 4'b0000);
        rst_n = 1'b1;

        // R1..R6, R10: table of arithmetic corner cases
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_en = 1'b1; c_in = 1'b0; v_in = 1'b0;
            drive_arith(VEC[i][69:68], VEC[i][67:36], VEC[i][35:4]);
            @(negedge clk);
            check($sformatf("R1 R2 R3 R4 R5 R6 vec %0d", i), {flag_n, flag_z, flag_c, flag_v}, VEC[i][3:0]);
            check($sformatf("R10 vec %0d", i), {upd_n, upd_z, upd_c, upd_v}, 4'b1111);
        end

        // R7: logical with shifter
        @(negedge clk);
        set_en = 1'b1; op_class = 2'b10; result = 32'h8000_0010;
        shf_cout = 1'b1; c_in = 1'b0; v_in = 1'b1;
        @(negedge clk);
        check("R7 flags", {flag_n, flag_z, flag_c, flag_v}, 4'b1011);
        check("R7 R10 enables", {upd_n, upd_z, upd_c, upd_v}, 4'b1110);

        // R8: logical without shifter
        @(negedge clk);
        op_class = 2'b11; result = '0; shf_cout = 1'b0; c_in = 1'b1; v_in = 1'b0;
        @(negedge clk);
        check("R8 flags", {flag_n, flag_z, flag_c, flag_v}, 4'b0110);
        check("R8 enables", {upd_n, upd_z, upd_c, upd_v}, 4'b1100);

        // R9: flag-set disabled on an overflowing add
        @(negedge clk);
        set_en = 1'b0; c_in = 1'b1; v_in = 1'b0;
        drive_arith(2'b00, 32'h7FFF_FFFF, 32'h0000_0001);
        @(negedge clk);
        check("R9 enables", {upd_n, upd_z, upd_c, upd_v}, 4'b0000);
        check("R9 carry/overflow held", {flag_c, flag_v}, 2'b10);

        // R11: one-cycle latency, output not yet changed right after drive
        @(negedge clk);
        set_en = 1'b1; c_in = 1'b0; v_in = 1'b0;
        drive_arith(2'b01, 32'h0000_0003, 32'h0000_0003);
        #1;
        check("R11 latency before edge", {upd_n, upd_z, upd_c, upd_v}, 4'b0000);
        @(negedge clk);
        check("R11 latency after edge", {flag_n, flag_z, flag_c, flag_v}, 4'b0110);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule